// File: doc/BRIEF.md
# Colour Palette Lookup Table with Sequenced Register Access

The block keeps a colour lookup table of 256 main entries and 4 overlay entries. Each entry holds three 8-bit components: red, green and blue. Software programs the table through a small 32-bit register window. It first loads an index. It then writes or reads one component per access, in the order red, green, blue. After the third access the index moves to the next entry. This lets a driver stream a whole palette with one index load. The overlay entries are written through the same sequencer at a second data offset. That offset uses only the low bits of the index.

A second, independent port serves the display pipeline. It takes an entry number (0 to 259) and returns the packed 24-bit colour one clock later. It has no wait states, and register traffic does not stall it. Offsets that belong to control registers accept writes and change nothing.

Top module: `palette_dac`

## Requirements
- R1: A write to byte offset 0 (address bits 3:2 = 0) loads the index from write-data bits 31:24 and returns the sequencer to the red step.
- R2: A write to byte offset 4 (address bits 3:2 = 1) stores write-data bits 31:24 into the current step's component of main entry `index`. Successive data accesses take the steps red, green, blue in that order.
- R3: A write to byte offset 12 (address bits 3:2 = 3) stores write-data bits 31:24 into the current step's component of overlay entry 256 + index[1:0]. Main entry `index` is left unchanged.
- R4: The first two accesses of a sequence leave the index unchanged. The access that takes the blue step increments the index modulo 256, so 255 becomes 0, and returns the sequencer to red.
- R5: A read at any offset returns the current step's component of main entry `index` in `reg_rdata[31:24]`, with bits 23:0 set to zero. The value is valid in the cycle after the read. The read advances the sequencer exactly as a data write does. `reg_rdata` holds its value between reads. When `reg_wr` and `reg_rd` are both high, only the write acts.
- R6: A write whose address bits 3:2 equal 2 (offset 8, a control register) changes no entry, no index and no sequencer step.
- R7: After reset, every entry is black (0x000000) except main entry 255 and overlay entries 256 and 258, which are white (0xFFFFFF). The index, the sequencer step and `reg_rdata` are zero.
- R8: The lookup port returns `{R,G,B}` (R in bits 23:16, G in 15:8, B in 7:0) of entry `lk_entry` one cycle after the entry number is presented. Entry numbers above 259 return 0.
- R9: If a lookup and a write address the same entry in the same cycle, the lookup returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| reg_wr | input | 1 | Register write strobe, one access per cycle |
| reg_rd | input | 1 | Register read strobe, one access per cycle |
| reg_addr | input | 4 | Byte offset within the register window |
| reg_wdata | input | 32 | Write data; components and index are taken from bits 31:24 |
| reg_rdata | output | 32 | Read data, registered; component in bits 31:24 |
| lk_entry | input | 9 | Entry number for the display lookup |
| lk_rgb | output | 24 | Registered colour of the looked-up entry |

## Verification
A corrupted index or sequencer step cannot be seen directly; it appears as a component landing in the wrong entry or the wrong colour lane. That error becomes visible on `lk_rgb` one cycle after the affected entry is looked up, or on `reg_rdata` at the next read. The bench therefore fills the whole main table through the auto-incrementing path, reads it back through both ports, and checks that the index wraps from 255 to 0 and that the index load cuts a sequence short. A wrong overlay decode shows up as an overlay entry keeping its reset colour, or as a main entry being overwritten. The same-cycle collision test detects lookup forwarding, which would expose the new value one cycle early.

// File: rtl/dac_pkg.sv
package dac_pkg;
  typedef enum logic [1:0] {
    STEP_RED   = 2'd0,
    STEP_GREEN = 2'd1,
    STEP_BLUE  = 2'd2
  } step_e;
endpackage

// File: rtl/dac_seq.sv
// Index register and red/green/blue step sequencer.
module dac_seq
  import dac_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [IDX_W-1:0] load_val,
  input  logic             adv_en,
  output logic [IDX_W-1:0] idx,
  output step_e            step
);
  logic [IDX_W-1:0] idx_q, idx_d;
  step_e            step_q, step_d;
  logic             upd_en;

  assign upd_en = load_en | adv_en;

  always_comb begin
    idx_d  = idx_q;
    step_d = step_q;
    if (load_en) begin
      idx_d  = load_val;
      step_d = STEP_RED;
    end else if (adv_en) begin
      case (step_q)
        STEP_RED:   step_d = STEP_GREEN;
        STEP_GREEN: step_d = STEP_BLUE;
        default: begin
          step_d = STEP_RED;
          idx_d  = idx_q + IDX_W'(1);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      step_q <= STEP_RED;
    end else if (upd_en) begin
      idx_q  <= idx_d;
      step_q <= step_d;
    end
  end

  assign idx  = idx_q;
  assign step = step_q;
endmodule

// File: rtl/dac_store.sv
// Colour entry storage with one component write port, a registered
// component read port and a registered full-colour lookup port.
module dac_store
  import dac_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int N_OVL  = 4,
  parameter int COMP_W = 8,
  localparam int NUM_MAIN = 1 << IDX_W,
  localparam int NUM_ENT  = NUM_MAIN + N_OVL,
  localparam int ENT_W    = $clog2(NUM_ENT),
  localparam int LW       = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ENT_W-1:0]  wr_ent,
  input  step_e             wr_step,
  input  logic [COMP_W-1:0] wr_val,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  step_e             rd_step,
  output logic [COMP_W-1:0] rd_comp,
  input  logic [ENT_W-1:0]  lk_ent,
  output logic [LW-1:0]     lk_rgb
);
  logic [LW-1:0] ent_q [NUM_ENT];

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    localparam bit WHITE = (e == NUM_MAIN - 1) ||
                           (e == NUM_MAIN) || (e == NUM_MAIN + 2);
    localparam logic [LW-1:0] RST_VAL = WHITE ? {LW{1'b1}} : {LW{1'b0}};
    logic          hit;
    logic [LW-1:0] val_q, val_d;

    assign hit = wr_en && (wr_ent == ENT_W'(e));

    always_comb begin
      val_d = val_q;
      case (wr_step)
        STEP_RED:   val_d[3*COMP_W-1:2*COMP_W] = wr_val;
        STEP_GREEN: val_d[2*COMP_W-1:COMP_W]   = wr_val;
        default:    val_d[COMP_W-1:0]          = wr_val;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= RST_VAL;
      else if (hit) val_q <= val_d;
    end

    assign ent_q[e] = val_q;
  end

  logic [LW-1:0]     lk_d, lk_q, rd_sel;
  logic [COMP_W-1:0] rd_d, rd_q;

  always_comb begin
    lk_d = '0;
    if (int'(lk_ent) < NUM_ENT) lk_d = ent_q[lk_ent];
  end

  always_comb begin
    rd_sel = ent_q[ENT_W'(rd_idx)];
    case (rd_step)
      STEP_RED:   rd_d = rd_sel[3*COMP_W-1:2*COMP_W];
      STEP_GREEN: rd_d = rd_sel[2*COMP_W-1:COMP_W];
      default:    rd_d = rd_sel[COMP_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lk_q <= '0;
    else        lk_q <= lk_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign lk_rgb  = lk_q;
  assign rd_comp = rd_q;
endmodule

// File: rtl/palette_dac.sv
module palette_dac
  import dac_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int N_OVL  = 4,
  parameter int COMP_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  localparam int NUM_MAIN = 1 << IDX_W,
  localparam int NUM_ENT  = NUM_MAIN + N_OVL,
  localparam int ENT_W    = $clog2(NUM_ENT),
  localparam int OVL_W    = (N_OVL > 1) ? $clog2(N_OVL) : 1,
  localparam int LW       = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [ENT_W-1:0]  lk_entry,
  output logic [LW-1:0]     lk_rgb
);
  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_n_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_n_sync <= rst_meta;
    end
  end

  logic [ADDR_W-3:0] word;
  logic              is_idx, is_main, is_ovl, load_en, data_wr, adv_en, rd_en;
  logic [IDX_W-1:0]  cur_idx;
  step_e             cur_step;
  logic [ENT_W-1:0]  wr_ent;
  logic [COMP_W-1:0] rd_comp;
  logic              unused_bits;

  assign word    = reg_addr[ADDR_W-1:2];
  assign is_idx  = (word == (ADDR_W-2)'(0));
  assign is_main = (word == (ADDR_W-2)'(1));
  assign is_ovl  = (word == (ADDR_W-2)'(3));
  assign load_en = reg_wr & is_idx;
  assign data_wr = reg_wr & (is_main | is_ovl);
  assign rd_en   = reg_rd & ~reg_wr;
  assign adv_en  = data_wr | rd_en;

  assign wr_ent = is_ovl ? ENT_W'(NUM_MAIN) + ENT_W'(cur_idx[OVL_W-1:0])
                         : ENT_W'(cur_idx);

  dac_seq #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load_en  (load_en),
    .load_val (reg_wdata[DATA_W-1 -: IDX_W]),
    .adv_en   (adv_en),
    .idx      (cur_idx),
    .step     (cur_step)
  );

  dac_store #(.IDX_W(IDX_W), .N_OVL(N_OVL), .COMP_W(COMP_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (data_wr),
    .wr_ent  (wr_ent),
    .wr_step (cur_step),
    .wr_val  (reg_wdata[DATA_W-1 -: COMP_W]),
    .rd_en   (rd_en),
    .rd_idx  (cur_idx),
    .rd_step (cur_step),
    .rd_comp (rd_comp),
    .lk_ent  (lk_entry),
    .lk_rgb  (lk_rgb)
  );

  assign reg_rdata   = {rd_comp, {(DATA_W-COMP_W){1'b0}}};
  assign unused_bits = ^{reg_addr[1:0], reg_wdata[DATA_W-COMP_W-1:0]};
endmodule

// File: rtl/palette_dac_chk.sv
module palette_dac_chk #(
  parameter int IDX_W   = 8,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int ENT_W   = 9,
  parameter int LW      = 24,
  parameter int NUM_ENT = 260
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [ENT_W-1:0]  lk_entry,
  input logic [LW-1:0]     lk_rgb,
  input logic [IDX_W-1:0]  cur_idx,
  input logic [1:0]        cur_step
);
  logic [ADDR_W-3:0] w;
  logic data_acc, ctrl_wr;
  assign w        = reg_addr[ADDR_W-1:2];
  assign data_acc = (reg_wr && (w == (ADDR_W-2)'(1) || w == (ADDR_W-2)'(3)))
                 || (reg_rd && !reg_wr);
  assign ctrl_wr  = reg_wr && w != (ADDR_W-2)'(0) && w != (ADDR_W-2)'(1)
                 && w != (ADDR_W-2)'(3);

  a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && w == (ADDR_W-2)'(0) |=>
      cur_idx == $past(reg_wdata[DATA_W-1 -: IDX_W]) && cur_step == 2'd0);

  a_r4_blue_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && cur_step == 2'd2 |=>
      cur_idx == $past(cur_idx) + IDX_W'(1) && cur_step == 2'd0);

  a_r4_hold_index: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc && cur_step != 2'd2 |=> $stable(cur_idx));

  a_r5_read_steps: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && !reg_wr && cur_step == 2'd0 |=> cur_step == 2'd1);

  a_r6_ctrl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> $stable(cur_idx) && $stable(cur_step));

  a_r8_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lk_entry) >= NUM_ENT |=> lk_rgb == '0);
endmodule

bind palette_dac palette_dac_chk #(
  .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .ENT_W(ENT_W), .LW(LW), .NUM_ENT(NUM_ENT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .lk_entry  (lk_entry),
  .lk_rgb    (lk_rgb),
  .cur_idx   (cur_idx),
  .cur_step  (cur_step)
);

// File: tb/tb_palette_dac.sv
`timescale 1ns/1ps
module tb_palette_dac;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [8:0]  lk_entry;
  logic [23:0] lk_rgb;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [23:0] exp_mem [260];

  always #4 clk = ~clk;

  palette_dac dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_entry(lk_entry), .lk_rgb(lk_rgb)
  );

  function automatic logic [7:0] pat(int i, int c);
    return 8'((i * 37 + c * 91 + 5) & 255);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = {v, 24'h5AC3E1};
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic look(int e, string req, logic [23:0] exp);
    lk_entry = 9'(e);
    @(negedge clk);
    check(req, {8'h0, lk_rgb}, {8'h0, exp});
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; lk_entry = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R7: reset contents
    check("R7 rdata", reg_rdata, 32'h0);
    for (int e = 0; e < 260; e++) begin
      exp_mem[e] = (e == 255 || e == 256 || e == 258) ? 24'hFFFFFF : 24'h0;
      look(e, "R7 reset entry", exp_mem[e]);
    end
    // R7: index and step cleared -> first read is red of entry 0
    rd(4'h4, v); check("R7 index/step", v, 32'h0);
    // R8: out of range entries
    look(260, "R8 range", 24'h0);
    look(511, "R8 range", 24'h0);

    // R2/R4: fill whole main table from index 0, wraps to 0
    wr(4'h0, 8'h00);
    for (int i = 0; i < 256; i++) begin
      for (int c = 0; c < 3; c++) wr(4'h4, pat(i, c));
      exp_mem[i] = {pat(i, 0), pat(i, 1), pat(i, 2)};
    end
    // R4 wrap: index is now 0; R5 read back through sequencer
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) begin
        rd(4'h4, v);
        check("R5 R4 readback", v, {pat(i, c), 24'h0});
      end
    for (int e = 0; e < 260; e++) look(e, "R2 R8 lookup", exp_mem[e]);

    // R3: overlay writes via index 0xA0..0xA3
    for (int o = 0; o < 4; o++) begin
      wr(4'h0, 8'hA0 | 8'(o));
      for (int c = 0; c < 3; c++) wr(4'hC, pat(300 + o, c));
      exp_mem[256 + o] = {pat(300 + o, 0), pat(300 + o, 1), pat(300 + o, 2)};
    end
    for (int o = 0; o < 4; o++) begin
      look(256 + o, "R3 overlay", exp_mem[256 + o]);
      look(160 + o, "R3 main untouched", exp_mem[160 + o]);
    end
    // R4: overlay sequence advanced index to 0xA4
    rd(4'h4, v); check("R4 after overlay", v, {exp_mem[164][23:16], 24'h0});

    // R1: index load mid-sequence restarts at red
    wr(4'h0, 8'd10);
    wr(4'h4, 8'h11);
    exp_mem[10][23:16] = 8'h11;
    wr(4'h0, 8'd20);
    wr(4'h4, 8'h21); wr(4'h4, 8'h22); wr(4'h4, 8'h23);
    exp_mem[20] = 24'h212223;
    look(10, "R1 partial", exp_mem[10]);
    look(20, "R1 restart", exp_mem[20]);

    // R6: control write mid-sequence has no effect
    wr(4'h0, 8'd30);
    wr(4'h4, 8'h31);
    wr(4'h8, 8'hEE);
    wr(4'h4, 8'h32); wr(4'h4, 8'h33);
    exp_mem[30] = 24'h313233;
    look(30, "R6 control ignored", exp_mem[30]);
    look(31, "R6 neighbour", exp_mem[31]);

    // R5: reads at control offset also step; both strobes -> write wins
    wr(4'h0, 8'd30);
    rd(4'h8, v); check("R5 read any offset", v, 32'h31000000);
    reg_wr = 1; reg_rd = 1; reg_addr = 4'h4; reg_wdata = {8'h44, 24'h0};
    @(negedge clk);
    reg_wr = 0; reg_rd = 0;
    exp_mem[30][15:8] = 8'h44;
    check("R5 rdata held", reg_rdata, 32'h31000000);
    rd(4'h4, v); check("R5 blue", v, 32'h33000000);
    look(30, "R5 write wins", exp_mem[30]);

    // R9: collision returns old value then new
    wr(4'h0, 8'd40);
    wr(4'h4, 8'h41); wr(4'h4, 8'h42);
    lk_entry = 9'd40;
    reg_wr = 1; reg_addr = 4'h4; reg_wdata = {8'h43, 24'h0};
    @(negedge clk);
    reg_wr = 0;
    check("R9 old value", {8'h0, lk_rgb}, {8'h0, 16'h4142, exp_mem[40][7:0]});
    exp_mem[40] = 24'h414243;
    @(negedge clk);
    check("R9 new value", {8'h0, lk_rgb}, {8'h0, exp_mem[40]});

    done = 1;
    finish_run();
  end
endmodule